// File: doc/BRIEF.md
# Nonvolatile Array Access and Program/Erase Controller

This block sits between the system bus and a 16-bit wide nonvolatile storage array, which it models as a register array. The bus reads the array at byte addresses in three widths: a single byte, a word at an even address, or a word at an odd address that straddles two storage words. Byte and even-word reads finish in the cycle they are requested. An odd-address word read stalls the bus for one extra cycle through a ready handshake. Words are big-endian: the byte at the even address is the upper half.

Changes to the array go through an interlocked command sequence. Software first arms the block by setting a latch bit together with the erase and size selects. It then writes a target address and data through the array write port, and finally sets the high-voltage enable bit. A pulse counter, loaded from the `pulse_cycles` input, holds `busy` high for the length of the program or erase pulse. The result is applied to the array when the pulse ends. Programming can only clear bits (a bitwise AND). Erase restores bytes to 0xFF over a byte, an aligned word, a 32-byte row or the whole array. When a program leaves the location different from the requested data, a failure flag is raised.

Top module: `eectl_top`

## Requirements
- R1: A byte read (`rd_word`=0) has `rd_ready` high in the request cycle and returns {8'h00, byte at `rd_addr`}.
- R2: A word read at an even address has `rd_ready` high in the request cycle and returns {byte at addr, byte at addr+1}.
- R3: A word read at an odd address holds `rd_ready` low in its first cycle and raises it in the second, returning {byte at addr, byte at addr+1}.
- R4: The command word `cmd_wdata` is laid out as bit0 = high-voltage enable, bit1 = latch, bit2 = erase, bits4:3 = size (0 byte, 1 word, 2 row, 3 whole array). An operation starts only when a command with both bit0 and bit1 set arrives while the latch is already set and an address has been written since the latch was armed. Any other enable write starts nothing. Array writes made while the latch is clear leave the array unchanged.
- R5: An operation holds `busy` high for exactly `pulse_cycles` cycles, starting at the enabling command's clock edge. A value of 0 counts as 1.
- R6: While `busy` is high, every read returns 0xFF in each byte it covers. Command and array writes made during that time are ignored, and the latch stays set.
- R7: Programming (erase bit 0) ANDs the data into the target. An array write with `arr_word`=1 at an even address targets the word. With `arr_word`=0 it targets the byte at the address, using `arr_wdata[7:0]`.
- R8: An array write with `arr_word`=1 at an odd address acts only on the byte at that address, using `arr_wdata[7:0]`. The byte at the next address is not touched, whether the operation programs or erases.
- R9: A byte or word erase sets the targeted byte or aligned word to 0xFF and leaves its neighbours unchanged.
- R10: A row erase sets all 32 bytes of the 32-byte-aligned row that holds the latched address to 0xFF. The low five address bits are ignored, and other rows are unchanged.
- R11: A whole-array erase sets every byte to 0xFF.
- R12: `prog_fail` rises at the end of a program whose resulting bytes differ from the requested data. It is cleared when the next operation starts. After reset the array reads 0xFF and `busy` and `prog_fail` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_word | input | 1 | 1 = word read, 0 = byte read |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_ready | output | 1 | Read data valid this cycle |
| rd_data | output | 16 | Read data (byte reads zero-extended) |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 5 | Command word (see R4) |
| arr_we | input | 1 | Array write strobe (latches target while armed) |
| arr_word | input | 1 | 1 = word write, 0 = byte write |
| arr_addr | input | ADDR_W | Target byte address |
| arr_wdata | input | 16 | Program data |
| pulse_cycles | input | PULSE_W | Program/erase pulse length in cycles |
| busy | output | 1 | Program/erase pulse in progress |
| prog_fail | output | 1 | Last program did not reach the requested data |

## Verification
On every cycle the bound checker checks the read handshake: single-cycle ready for byte and even-word reads, and a stall of exactly one cycle for odd-word reads. It also checks that reads during a pulse return 0xFF, that the pulse length matches the programmed count, and that an enable without the latch never starts a pulse. It further checks that the failure flag is clear at every pulse start. Only the bench scenarios can show the array contents after each operation: AND-only programming, the lower-byte-only effect of odd-word writes, the exact extent of byte, word, row and whole-array erase, and the latch surviving a write attempted during a pulse.

// File: rtl/eectl_pkg.sv
package eectl_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_ROW  = 2'd2,
        SZ_ALL  = 2'd3
    } ee_size_e;

    // command register layout, MSB first
    typedef struct packed {
        ee_size_e size;
        logic     erase;
        logic     latch;
        logic     hv;
    } ee_cmd_t;

    typedef struct packed {
        ee_size_e size;
        logic     erase;
    } ee_sel_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    // big-endian lane select: even byte address is the upper half
    function automatic logic [7:0] pick_byte(input logic [15:0] w, input logic odd);
        return odd ? w[7:0] : w[15:8];
    endfunction

    function automatic logic [15:0] lane_mask(input logic wide, input logic odd);
        if (wide)
            return 16'hFFFF;
        return odd ? 16'h00FF : 16'hFF00;
    endfunction

endpackage

// File: rtl/eectl_seq.sv
module eectl_seq
    import eectl_pkg::*;
#(
    parameter int ADDR_W  = 9,
    parameter int PULSE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_we,
    input  ee_cmd_t            cmd,
    input  logic               arr_we,
    input  logic               arr_word,
    input  logic [ADDR_W-1:0]  arr_addr,
    input  logic [15:0]        arr_wdata,
    input  logic [PULSE_W-1:0] pulse_cycles,
    output logic               busy,
    output logic               start,
    output logic               commit,
    output logic [ADDR_W-1:0]  op_addr,
    output logic [15:0]        op_data,
    output ee_size_e           op_size,
    output logic               op_erase
);
    logic               latch_q;
    ee_sel_t            sel_q;
    logic               addr_ok_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [15:0]        data_q;
    logic               wide_q;
    logic               busy_q;
    logic [PULSE_W-1:0] cnt_q;
    logic [PULSE_W-1:0] eff_len;

    assign eff_len = (pulse_cycles == '0) ? PULSE_W'(1) : pulse_cycles;
    assign start   = !busy_q && cmd_we && cmd.hv && cmd.latch && latch_q && addr_ok_q;
    assign commit  = busy_q && (cnt_q == PULSE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q   <= 1'b0;
            sel_q     <= '{size: SZ_BYTE, erase: 1'b0};
            addr_ok_q <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
            wide_q    <= 1'b0;
            busy_q    <= 1'b0;
            cnt_q     <= '0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - PULSE_W'(1);
            if (commit) begin
                busy_q    <= 1'b0;
                addr_ok_q <= 1'b0;
            end
        end else if (cmd_we) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= eff_len;
            end else begin
                latch_q     <= cmd.latch;
                sel_q.size  <= cmd.size;
                sel_q.erase <= cmd.erase;
                if (cmd.latch != latch_q)
                    addr_ok_q <= 1'b0;
            end
        end else if (arr_we && latch_q) begin
            addr_q    <= arr_addr;
            data_q    <= arr_wdata;
            wide_q    <= arr_word && !arr_addr[0];
            addr_ok_q <= 1'b1;
        end
    end

    always_comb begin
        if (sel_q.erase)
            op_size = (sel_q.size == SZ_WORD && addr_q[0]) ? SZ_BYTE : sel_q.size;
        else
            op_size = wide_q ? SZ_WORD : SZ_BYTE;
    end

    assign busy     = busy_q;
    assign op_addr  = addr_q;
    assign op_data  = data_q;
    assign op_erase = sel_q.erase;

endmodule

// File: rtl/eectl_array.sv
module eectl_array
    import eectl_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int ROW_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              commit,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [15:0]       op_data,
    input  ee_size_e          op_size,
    input  logic              op_erase,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_b0,
    output logic [7:0]        rd_b1,
    output logic              prog_fail
);
    localparam int WA_W   = ADDR_W - 1;
    localparam int WORDS  = 1 << WA_W;
    localparam int ROW_SH = $clog2(ROW_BYTES);

    logic [15:0]     mem [WORDS];
    logic [WORDS-1:0] hit_hi;
    logic [WORDS-1:0] hit_lo;
    logic [WA_W-1:0] tgt;
    logic            odd;
    logic [15:0]     pdata;
    logic [15:0]     pmask;
    logic [15:0]     cur;
    logic [ADDR_W-1:0] rd_next;

    assign tgt   = op_addr[ADDR_W-1:1];
    assign odd   = op_addr[0];
    assign pmask = lane_mask(op_size == SZ_WORD, odd);
    assign pdata = (op_size == SZ_WORD) ? op_data
                 : odd ? {ERASED_BYTE, op_data[7:0]} : {op_data[7:0], ERASED_BYTE};
    assign cur   = mem[tgt];

    // per-word erase lane decode
    for (genvar w = 0; w < WORDS; w++) begin : g_hit
        localparam logic [WA_W-1:0] WIDX = WA_W'(w);
        logic same, row;
        assign same = (WIDX == tgt);
        assign row  = (WIDX >> (ROW_SH - 1)) == (tgt >> (ROW_SH - 1));
        always_comb begin
            unique case (op_size)
                SZ_BYTE: begin hit_hi[w] = same && !odd; hit_lo[w] = same && odd; end
                SZ_WORD: begin hit_hi[w] = same;         hit_lo[w] = same;        end
                SZ_ROW:  begin hit_hi[w] = row;          hit_lo[w] = row;         end
                default: begin hit_hi[w] = 1'b1;         hit_lo[w] = 1'b1;        end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++)
                mem[i] <= 16'hFFFF;
            prog_fail <= 1'b0;
        end else begin
            if (start)
                prog_fail <= 1'b0;
            if (commit) begin
                if (op_erase) begin
                    for (int i = 0; i < WORDS; i++) begin
                        if (hit_hi[i]) mem[i][15:8] <= ERASED_BYTE;
                        if (hit_lo[i]) mem[i][7:0]  <= ERASED_BYTE;
                    end
                end else begin
                    mem[tgt]  <= cur & pdata;
                    prog_fail <= ((cur & pdata & pmask) != (pdata & pmask));
                end
            end
        end
    end

    assign rd_next = rd_addr + ADDR_W'(1);
    assign rd_b0   = pick_byte(mem[rd_addr[ADDR_W-1:1]], rd_addr[0]);
    assign rd_b1   = pick_byte(mem[rd_next[ADDR_W-1:1]], rd_next[0]);

endmodule

// File: rtl/eectl_rdpath.sv
module eectl_rdpath
    import eectl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_req,
    input  logic        rd_word,
    input  logic        rd_odd,
    input  logic        busy,
    input  logic [7:0]  b0,
    input  logic [7:0]  b1,
    output logic        rd_ready,
    output logic [15:0] rd_data
);
    logic straddle;
    logic phase_q;
    logic [7:0] hi_b, lo_b;

    assign straddle = rd_req && rd_word && rd_odd;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= 1'b0;
        else
            phase_q <= straddle && !phase_q;
    end

    assign rd_ready = !(straddle && !phase_q);
    assign hi_b     = busy ? ERASED_BYTE : b0;
    assign lo_b     = busy ? ERASED_BYTE : b1;
    assign rd_data  = rd_word ? {hi_b, lo_b} : {8'h00, hi_b};

endmodule

// File: rtl/eectl_top.sv
module eectl_top
    import eectl_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int ROW_BYTES = 32,
    parameter int PULSE_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_req,
    input  logic               rd_word,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_ready,
    output logic [15:0]        rd_data,
    input  logic               cmd_we,
    input  logic [4:0]         cmd_wdata,
    input  logic               arr_we,
    input  logic               arr_word,
    input  logic [ADDR_W-1:0]  arr_addr,
    input  logic [15:0]        arr_wdata,
    input  logic [PULSE_W-1:0] pulse_cycles,
    output logic               busy,
    output logic               prog_fail
);
    ee_cmd_t           cmd;
    logic              start, commit, op_erase;
    logic [ADDR_W-1:0] op_addr;
    logic [15:0]       op_data;
    ee_size_e          op_size;
    logic [7:0]        b0, b1;

    assign cmd = ee_cmd_t'(cmd_wdata);

    eectl_seq #(.ADDR_W(ADDR_W), .PULSE_W(PULSE_W)) u_seq (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd(cmd),
        .arr_we(arr_we), .arr_word(arr_word), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .pulse_cycles(pulse_cycles), .busy(busy), .start(start), .commit(commit),
        .op_addr(op_addr), .op_data(op_data), .op_size(op_size), .op_erase(op_erase)
    );

    eectl_array #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) u_array (
        .clk(clk), .rst(rst), .start(start), .commit(commit),
        .op_addr(op_addr), .op_data(op_data), .op_size(op_size), .op_erase(op_erase),
        .rd_addr(rd_addr), .rd_b0(b0), .rd_b1(b1), .prog_fail(prog_fail)
    );

    eectl_rdpath u_rd (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_word(rd_word), .rd_odd(rd_addr[0]),
        .busy(busy), .b0(b0), .b1(b1), .rd_ready(rd_ready), .rd_data(rd_data)
    );

endmodule

// File: rtl/eectl_chk.sv
module eectl_chk #(
    parameter int PULSE_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               rd_req,
    input logic               rd_word,
    input logic               rd_addr0,
    input logic               rd_ready,
    input logic [15:0]        rd_data,
    input logic               cmd_we,
    input logic [4:0]         cmd_wdata,
    input logic [PULSE_W-1:0] pulse_cycles,
    input logic               busy,
    input logic               prog_fail
);
    logic [PULSE_W-1:0] run_cnt;
    logic [PULSE_W-1:0] len_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            len_cap <= PULSE_W'(1);
        end else begin
            run_cnt <= busy ? run_cnt + PULSE_W'(1) : '0;
            if (!busy)
                len_cap <= (pulse_cycles == '0) ? PULSE_W'(1) : pulse_cycles;
        end
    end

    // R1 R2
    fast_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && !(rd_word && rd_addr0) |-> rd_ready);

    // R3
    straddle_done_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && rd_word && rd_addr0 && !rd_ready |=> (rd_ready || !rd_req));

    // R4
    no_stray_hv_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_we && cmd_wdata[0] && !cmd_wdata[1] && !busy |=> !busy);

    // R5
    pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && (run_cnt < len_cap - PULSE_W'(1)) |=> busy);

    // R5
    pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
        busy && (run_cnt == len_cap - PULSE_W'(1)) |=> !busy);

    // R6
    busy_read_chk: assert property (@(posedge clk) disable iff (rst)
        busy && rd_req && rd_ready |-> rd_data == (rd_word ? 16'hFFFF : 16'h00FF));

    // R12
    fail_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !prog_fail);

endmodule

bind eectl_top eectl_chk #(.PULSE_W(PULSE_W)) u_chk (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_word(rd_word), .rd_addr0(rd_addr[0]),
    .rd_ready(rd_ready), .rd_data(rd_data), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .pulse_cycles(pulse_cycles), .busy(busy), .prog_fail(prog_fail)
);

// File: tb/eectl_top_bench.sv
module eectl_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          word;
        logic [15:0]   exp;
        logic [1:0]    cyc;
    } rv_t;

    // reads after programming 0x10=1234 (word), 0x13=A5 (byte), 0x15 odd word BEEF
    localparam rv_t RV [9] = '{
        '{9'h010, 1'b0, 16'h0012, 2'd1},   // R1
        '{9'h011, 1'b0, 16'h0034, 2'd1},   // R1
        '{9'h010, 1'b1, 16'h1234, 2'd1},   // R2
        '{9'h012, 1'b1, 16'hFFA5, 2'd1},   // R2
        '{9'h011, 1'b1, 16'h34FF, 2'd2},   // R3
        '{9'h013, 1'b1, 16'hA5FF, 2'd2},   // R3
        '{9'h015, 1'b1, 16'hEFFF, 2'd2},   // R8
        '{9'h014, 1'b1, 16'hFFEF, 2'd1},   // R8
        '{9'h016, 1'b0, 16'h00FF, 2'd1}    // R8
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_req = 1'b0, rd_word = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic rd_ready;
    logic [15:0] rd_data;
    logic cmd_we = 1'b0;
    logic [4:0] cmd_wdata = '0;
    logic arr_we = 1'b0, arr_word = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [15:0] arr_wdata = '0;
    logic [15:0] pulse_cycles = 16'd5;
    logic busy, prog_fail;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eectl_top u_eectl_top (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_word(rd_word), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .arr_we(arr_we), .arr_word(arr_word), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .pulse_cycles(pulse_cycles), .busy(busy), .prog_fail(prog_fail)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks enter and leave one time unit after a rising edge
    task automatic cmd(input logic [4:0] v);
        cmd_we = 1'b1; cmd_wdata = v;
        @(posedge clk); #1;
        cmd_we = 1'b0;
    endtask

    task automatic awr(input logic [AW-1:0] a, input logic [15:0] d, input logic w);
        arr_we = 1'b1; arr_addr = a; arr_wdata = d; arr_word = w;
        @(posedge clk); #1;
        arr_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a, input logic w,
                      input logic [15:0] exp, input int exp_cyc);
        int cyc = 1;
        rd_req = 1'b1; rd_addr = a; rd_word = w;
        @(negedge clk);
        while (!rd_ready && cyc < 8) begin
            @(posedge clk); cyc++; @(negedge clk);
        end
        chk({tag, " data"}, rd_data, exp);
        chk({tag, " cycles"}, 16'(cyc), 16'(exp_cyc));
        @(posedge clk); #1;
        rd_req = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (!busy || n > 70000) break;
            n++;
        end
        @(posedge clk); #1;
    endtask

    task automatic run_op(input string tag, input logic [4:0] hv_cmd, input int exp_len);
        int n;
        cmd(hv_cmd);
        wait_idle(n);
        if (exp_len > 0)
            chk({tag, " busy length"}, 16'(n), 16'(exp_len));
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [15:0] d, input logic w);
        cmd(5'h02);
        awr(a, d, w);
        run_op("program", 5'h03, 0);
    endtask

    task automatic erase(input logic [AW-1:0] a, input logic [1:0] sz);
        cmd({sz, 3'b110});
        awr(a, 16'h0000, 1'b0);
        run_op("erase", {sz, 3'b111}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R12 reset state
        chk("R12 reset busy", 16'(busy), 16'h0);
        chk("R12 reset prog_fail", 16'(prog_fail), 16'h0);
        rd("R1 reset erased byte", 9'h000, 1'b0, 16'h00FF, 1);

        // R5 R7 aligned word program with pulse length 5
        cmd(5'h02);
        awr(9'h010, 16'h1234, 1'b1);
        run_op("R5 R7", 5'h03, 5);
        chk("R12 clean program", 16'(prog_fail), 16'h0);
        prog(9'h013, 16'h00A5, 1'b0);           // R7 byte
        prog(9'h015, 16'hBEEF, 1'b1);           // R8 odd word acts on 0x15 only

        for (int i = 0; i < 9; i++)
            rd($sformatf("R1 R2 R3 R8 table %0d", i), RV[i].addr, RV[i].word,
               RV[i].exp, int'(RV[i].cyc));

        // R7 R12 program over unerased byte: 0x12 & 0x0F = 0x02
        prog(9'h010, 16'h000F, 1'b0);
        chk("R12 fail raised", 16'(prog_fail), 16'h1);
        rd("R7 AND result", 9'h010, 1'b0, 16'h0002, 1);

        // R4 interlock
        cmd(5'h00);
        awr(9'h020, 16'h0000, 1'b1);
        rd("R4 write without latch", 9'h020, 1'b1, 16'hFFFF, 1);
        cmd(5'h01);
        chk("R4 enable without latch", 16'(busy), 16'h0);
        cmd(5'h02);
        cmd(5'h03);
        chk("R4 enable without address", 16'(busy), 16'h0);

        // R6 busy behaviour, R12 clear on next start
        pulse_cycles = 16'd8;
        awr(9'h020, 16'h005A, 1'b0);
        cmd(5'h03);
        chk("R6 busy started", 16'(busy), 16'h1);
        chk("R12 fail cleared at start", 16'(prog_fail), 16'h0);
        rd("R6 read while busy", 9'h010, 1'b1, 16'hFFFF, 1);
        cmd(5'h00);                              // attempt to drop latch
        run_op("R6", 5'h00, 0);
        awr(9'h021, 16'h003C, 1'b0);
        cmd(5'h03);
        chk("R6 latch kept", 16'(busy), 16'h1);
        run_op("R6 tail", 5'h00, 0);
        rd("R6 R7 both bytes", 9'h020, 1'b1, 16'h5A3C, 1);

        // R5 zero length counts as one
        pulse_cycles = 16'd0;
        cmd(5'h02);
        awr(9'h016, 16'h0077, 1'b0);
        run_op("R5 zero", 5'h03, 1);
        pulse_cycles = 16'd4;

        // R9 byte and word erase
        erase(9'h010, 2'd0);
        rd("R9 byte erased", 9'h010, 1'b0, 16'h00FF, 1);
        rd("R9 neighbour kept", 9'h011, 1'b0, 16'h0034, 1);
        erase(9'h012, 2'd1);
        rd("R9 word erased", 9'h012, 1'b1, 16'hFFFF, 1);

        // R8 odd word erase touches 0x15 only
        erase(9'h015, 2'd1);
        rd("R8 odd erase", 9'h015, 1'b1, 16'hFF77, 2);

        // R10 row erase at 0x2B clears 0x20..0x3F
        prog(9'h03F, 16'h0011, 1'b0);
        prog(9'h040, 16'h0022, 1'b0);
        erase(9'h02B, 2'd2);
        rd("R10 row start", 9'h020, 1'b1, 16'hFFFF, 1);
        rd("R10 row end", 9'h03E, 1'b1, 16'hFFFF, 1);
        rd("R10 next row kept", 9'h040, 1'b0, 16'h0022, 1);
        rd("R10 other row kept", 9'h011, 1'b0, 16'h0034, 1);

        // R11 whole array
        erase(9'h000, 2'd3);
        rd("R11 low", 9'h011, 1'b0, 16'h00FF, 1);
        rd("R11 high", 9'h040, 1'b0, 16'h00FF, 1);
        rd("R11 odd word", 9'h015, 1'b1, 16'hFFFF, 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule